// File: doc/BRIEF.md
# Skewed Four-Bank Transpose Buffer

This block holds the intermediate values of a 2-D inverse transform between its first and second 1-D pass. The first pass stores four values of one row per cycle. The second pass then fetches four values per cycle, either along a row or down a column. Fetching down a column gives the second pass its input in transposed order without any shuffling outside the block. Square blocks of 4, 8, 16 or 32 values per side are supported. A smaller block is packed densely at the low addresses, so every size uses the same storage.

The storage is four memory banks, each with one write port and one read port, rather than a flip-flop array. The position of each value inside its 4x4 tile sets its bank: value (row r, column c) lives in bank (r + c) mod 4. Four values along a row therefore touch all four banks once, and so do four values down a column. The write and read paths rotate the four lanes by this skew, so the ports always present values in natural index order.

A read is accepted in the cycle it is requested, and its data appears one cycle later. A write and a read to the same 4x4 tile in one cycle are a conflict. The write wins and the read is refused for that cycle.

Top module: `tpose_buf`

## Requirements
- R1: After reset, rd_valid is 0 and stays 0 until a read is accepted.
- R2: A write stores wr_data lane k (bits 16k+15:16k) as the value at row wr_row, column 4*wr_grp+k. A row read (rd_col=0) of row rd_idx and group rd_grp returns, in lane k, the value at column 4*rd_grp+k.
- R3: A column read (rd_col=1) of column rd_idx and group rd_grp returns, in lane k, the value at row 4*rd_grp+k of that column.
- R4: rd_ready is 1 exactly when rd_en is 1 and the request is accepted. rd_valid is 1 in the cycle after an accepted read, with rd_data holding the result, and is 0 otherwise.
- R5: Consider a cycle with an in-block write and a read whose 4x4 tile is the write's tile. For a row read that tile is (rd_idx/4, rd_grp); for a column read it is (rd_grp, rd_idx/4). In such a cycle rd_ready is 0, no rd_valid follows, and the write is still stored.
- R6: A read of a different tile is accepted in the same cycle as a write, and it returns the data held before that write.
- R7: blk_size codes 0, 1, 2 and 3 select block sides of 4, 8, 16 and 32. For each size, filling the whole block by rows and reading it back by columns returns the exact transpose.
- R8: A write outside the selected block is ignored. Its row, or its first column 4*wr_grp, being at least the block side makes it outside, and no stored value changes. A read outside the block is refused (rd_ready 0, no rd_valid).
- R9: Reads requested on consecutive cycles are each accepted, and each returns its result one cycle after its request. This gives four values per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| blk_size | input | 2 | Block side code: 0=4, 1=8, 2=16, 3=32 |
| wr_en | input | 1 | Write request |
| wr_row | input | 5 | Row being written |
| wr_grp | input | 3 | Column quartet being written |
| wr_data | input | 64 | Four values, lane k at bits 16k+15:16k |
| rd_en | input | 1 | Read request |
| rd_col | input | 1 | 0 = row read, 1 = column read |
| rd_idx | input | 5 | Row (row read) or column (column read) index |
| rd_grp | input | 3 | Quartet along the read line |
| rd_ready | output | 1 | Read request accepted this cycle |
| rd_valid | output | 1 | rd_data holds the result of last cycle's accepted read |
| rd_data | output | 64 | Four values read, natural order |

## Verification
Suppose a bank choice or a lane rotation is wrong. Row reads might still round-trip, but the first column read returns values in the wrong lanes or from the wrong rows, one cycle after its request. The column sweep at every block size covers every bank address. An error in the dense address packing for one size therefore shows as a mismatch in that size's sweep. A faulty tile compare shows in the same cycle as the request, either as a wrong rd_ready or as a read result that is missing or stale a cycle later.

// File: rtl/tpose_pkg.sv
package tpose_pkg;
  localparam int LANES = 4;

  // block side selected by the size code
  function automatic int blk_side(input logic [1:0] code);
    return 4 << code;
  endfunction

  // dense word address of a quartet: one word per quartet, rows of side/4 words
  function automatic int quartet_addr(input int row, input int grp, input logic [1:0] code);
    return (row << code) + grp;
  endfunction

  // is the quartet starting at (row, 4*grp) inside the block
  function automatic bit quartet_inside(input int row, input int grp, input logic [1:0] code);
    return (row < blk_side(code)) && ((grp * 4) < blk_side(code));
  endfunction

  // lane served by a bank given the skew term of the access
  function automatic logic [1:0] lane_of_bank(input logic [1:0] bank, input logic [1:0] skew);
    return bank - skew;
  endfunction
endpackage

// File: rtl/tpose_bank.sv
module tpose_bank #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW:0]       words,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

  // R7: dense packing keeps every access inside the words of the chosen size
  p_waddr_in_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> ({1'b0, waddr} < words));
  p_raddr_in_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    re |-> ({1'b0, raddr} < words));
endmodule

// File: rtl/tpose_wr_map.sv
module tpose_wr_map
  import tpose_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int MAX_N  = 32,
  localparam int IW    = $clog2(MAX_N),
  localparam int GW    = $clog2(MAX_N / 4),
  localparam int AW    = $clog2(MAX_N * MAX_N / 4)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [1:0]                    blk_size,
  input  logic                          wr_en,
  input  logic [IW-1:0]                 wr_row,
  input  logic [GW-1:0]                 wr_grp,
  input  logic [LANES*DATA_W-1:0]       wr_data,
  output logic [LANES-1:0]              bank_we,
  output logic [AW-1:0]                 bank_waddr,
  output logic [LANES-1:0][DATA_W-1:0]  bank_wdata
);
  logic       wr_inside;
  logic [3:0] lane_hit;

  assign wr_inside  = wr_en && quartet_inside(int'(wr_row), int'(wr_grp), blk_size);
  assign bank_waddr = AW'(quartet_addr(int'(wr_row), int'(wr_grp), blk_size));

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    logic [1:0] lane;
    assign lane          = lane_of_bank(2'(b), wr_row[1:0]);
    assign bank_we[b]    = wr_inside;
    assign bank_wdata[b] = wr_data[int'(lane)*DATA_W +: DATA_W];
  end

  always_comb begin
    lane_hit = '0;
    for (int b = 0; b < LANES; b++) lane_hit[g_lane_sel(b)] = 1'b1;
  end

  function automatic logic [1:0] g_lane_sel(input int b);
    return lane_of_bank(2'(b), wr_row[1:0]);
  endfunction

  // R2: the four banks of one write take the four lanes exactly once
  p_lanes_cover_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_we) |-> (lane_hit == 4'hF));
endmodule

// File: rtl/tpose_rd_map.sv
module tpose_rd_map
  import tpose_pkg::*;
#(
  parameter int MAX_N = 32,
  localparam int IW   = $clog2(MAX_N),
  localparam int GW   = $clog2(MAX_N / 4),
  localparam int AW   = $clog2(MAX_N * MAX_N / 4)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                blk_size,
  input  logic                      rd_en,
  input  logic                      rd_col,
  input  logic [IW-1:0]             rd_idx,
  input  logic [GW-1:0]             rd_grp,
  input  logic                      wr_en,
  input  logic [IW-1:0]             wr_row,
  input  logic [GW-1:0]             wr_grp,
  output logic                      accept,
  output logic                      clash,
  output logic [LANES-1:0]          bank_re,
  output logic [LANES-1:0][AW-1:0]  bank_raddr
);
  logic          rd_inside;
  logic          wr_inside;
  logic [GW-1:0] rd_tile_r;
  logic [GW-1:0] rd_tile_c;
  logic [GW-1:0] rd_line;

  assign rd_line   = rd_idx[IW-1:2];
  assign rd_tile_r = rd_col ? rd_grp : rd_line;
  assign rd_tile_c = rd_col ? rd_line : rd_grp;

  // in a column read the line index is a column, the quartet runs down rows
  assign rd_inside = rd_col ? quartet_inside(int'(rd_grp) * 4, int'(rd_line), blk_size) &&
                              (int'(rd_idx) < blk_side(blk_size))
                            : quartet_inside(int'(rd_idx), int'(rd_grp), blk_size);
  assign wr_inside = wr_en && quartet_inside(int'(wr_row), int'(wr_grp), blk_size);

  assign clash  = rd_en && wr_inside &&
                  (rd_tile_r == wr_row[IW-1:2]) && (rd_tile_c == wr_grp);
  assign accept = rd_en && rd_inside && !clash;

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    logic [1:0] lane;
    int         row;
    assign lane          = lane_of_bank(2'(b), rd_idx[1:0]);
    assign row           = rd_col ? (int'(rd_grp) * 4 + int'(lane)) : int'(rd_idx);
    assign bank_re[b]    = accept;
    assign bank_raddr[b] = rd_col ? AW'(quartet_addr(row, int'(rd_line), blk_size))
                                  : AW'(quartet_addr(row, int'(rd_grp), blk_size));
  end

  // R3: a column read spreads over distinct word addresses, one per row
  p_col_addr_distinct_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && rd_col) |-> (bank_raddr[0] != bank_raddr[1]) && (bank_raddr[2] != bank_raddr[3]));
  // R2: a row read uses one word address in every bank
  p_row_addr_shared_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !rd_col) |-> (bank_raddr[0] == bank_raddr[3]));
endmodule

// File: rtl/tpose_buf.sv
module tpose_buf
  import tpose_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int MAX_N  = 32,
  localparam int IW    = $clog2(MAX_N),
  localparam int GW    = $clog2(MAX_N / 4),
  localparam int DEPTH = MAX_N * MAX_N / 4,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              blk_size,
  input  logic                    wr_en,
  input  logic [IW-1:0]           wr_row,
  input  logic [GW-1:0]           wr_grp,
  input  logic [LANES*DATA_W-1:0] wr_data,
  input  logic                    rd_en,
  input  logic                    rd_col,
  input  logic [IW-1:0]           rd_idx,
  input  logic [GW-1:0]           rd_grp,
  output logic                    rd_ready,
  output logic                    rd_valid,
  output logic [LANES*DATA_W-1:0] rd_data
);
  logic [LANES-1:0]             bank_we;
  logic [AW-1:0]                bank_waddr;
  logic [LANES-1:0][DATA_W-1:0] bank_wdata;
  logic [LANES-1:0]             bank_re;
  logic [LANES-1:0][AW-1:0]     bank_raddr;
  logic [LANES-1:0][DATA_W-1:0] bank_q;
  logic                         accept;
  logic                         clash;
  logic [1:0]                   skew_q;
  logic [AW:0]                  words;

  assign words = (AW + 1)'(blk_side(blk_size) * blk_side(blk_size) / 4);

  tpose_wr_map #(.DATA_W(DATA_W), .MAX_N(MAX_N)) u_wr_map (
    .clk(clk), .rst_n(rst_n), .blk_size(blk_size), .wr_en(wr_en),
    .wr_row(wr_row), .wr_grp(wr_grp), .wr_data(wr_data),
    .bank_we(bank_we), .bank_waddr(bank_waddr), .bank_wdata(bank_wdata)
  );

  tpose_rd_map #(.MAX_N(MAX_N)) u_rd_map (
    .clk(clk), .rst_n(rst_n), .blk_size(blk_size), .rd_en(rd_en),
    .rd_col(rd_col), .rd_idx(rd_idx), .rd_grp(rd_grp),
    .wr_en(wr_en), .wr_row(wr_row), .wr_grp(wr_grp),
    .accept(accept), .clash(clash), .bank_re(bank_re), .bank_raddr(bank_raddr)
  );

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    tpose_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_bank (
      .clk(clk), .rst_n(rst_n), .words(words),
      .we(bank_we[b]), .waddr(bank_waddr), .wdata(bank_wdata[b]),
      .re(bank_re[b]), .raddr(bank_raddr[b]), .rdata(bank_q[b])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      skew_q   <= '0;
    end else begin
      rd_valid <= accept;
      if (accept) skew_q <= rd_idx[1:0];
    end
  end

  assign rd_ready = accept;

  // undo the bank skew: lane k comes from bank (skew + k) mod 4
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [1:0] src;
    assign src = skew_q + 2'(k);
    assign rd_data[k*DATA_W +: DATA_W] = bank_q[src];
  end

  // R4: results appear only one cycle after an accepted request
  p_valid_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_en && rd_ready));
  p_no_valid_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  // R5: a read sharing the write's tile is refused
  p_clash_refused_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clash |-> !rd_ready);
  // R8: nothing outside the block is accepted
  p_inside_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> (int'(rd_idx) < blk_side(blk_size)) && (int'(rd_grp) * 4 < blk_side(blk_size)));
endmodule

// File: tb/tpose_buf_bench.sv
module tpose_buf_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  blk_size = '0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_row = '0;
  logic [2:0]  wr_grp = '0;
  logic [63:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic        rd_col = 1'b0;
  logic [4:0]  rd_idx = '0;
  logic [2:0]  rd_grp = '0;
  logic        rd_ready;
  logic        rd_valid;
  logic [63:0] rd_data;

  int checks = 0;
  int fails  = 0;
  logic [15:0] model [32][32];

  always #4 clk = ~clk;

  tpose_buf u_tpose_buf (
    .clk(clk), .rst_n(rst_n), .blk_size(blk_size), .wr_en(wr_en), .wr_row(wr_row),
    .wr_grp(wr_grp), .wr_data(wr_data), .rd_en(rd_en), .rd_col(rd_col),
    .rd_idx(rd_idx), .rd_grp(rd_grp), .rd_ready(rd_ready), .rd_valid(rd_valid),
    .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int tag, input int r, input int c);
    return 16'(tag * 1024 + r * 32 + c);
  endfunction

  function automatic int side(input int code);
    return 4 << code;
  endfunction

  function automatic logic [63:0] row_exp(input int r, input int g);
    logic [63:0] v;
    for (int k = 0; k < 4; k++) v[k*16 +: 16] = model[r][4*g+k];
    return v;
  endfunction

  function automatic logic [63:0] col_exp(input int c, input int g);
    logic [63:0] v;
    for (int k = 0; k < 4; k++) v[k*16 +: 16] = model[4*g+k][c];
    return v;
  endfunction

  // drive one write for one cycle; model follows when inside the block
  task automatic put_row(input int r, input int g, input int tag);
    logic [63:0] d;
    for (int k = 0; k < 4; k++) d[k*16 +: 16] = pat(tag, r, 4*g+k);
    @(negedge clk);
    wr_en = 1'b1; wr_row = 5'(r); wr_grp = 3'(g); wr_data = d;
    if (r < side(blk_size) && 4*g < side(blk_size))
      for (int k = 0; k < 4; k++) model[r][4*g+k] = d[k*16 +: 16];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // one read; checks acceptance and, when accepted, the returned data
  task automatic get(input bit col, input int idx, input int g, input bit want_ok, input string req);
    logic [63:0] e;
    @(negedge clk);
    rd_en = 1'b1; rd_col = col; rd_idx = 5'(idx); rd_grp = 3'(g);
    e = col ? col_exp(idx, g) : row_exp(idx, g);
    #1;
    chk(rd_ready == want_ok, req, 64'(rd_ready), 64'(want_ok));
    @(negedge clk);
    rd_en = 1'b0;
    chk(rd_valid == want_ok, req, 64'(rd_valid), 64'(want_ok));
    if (want_ok) chk(rd_data == e, req, rd_data, e);
  endtask

  task automatic fill(input int tag);
    for (int r = 0; r < side(blk_size); r++)
      for (int g = 0; g < side(blk_size) / 4; g++) put_row(r, g, tag);
  endtask

  task automatic t_reset_r1;
    chk(rd_valid == 1'b0, "R1 reset", 64'(rd_valid), 64'(0));
    @(negedge clk);
    chk(rd_valid == 1'b0, "R1 idle", 64'(rd_valid), 64'(0));
  endtask

  task automatic t_row_col_r2_r3;
    blk_size = 2'd3;
    put_row(5, 2, 1);
    put_row(6, 2, 1);
    put_row(7, 2, 1);
    put_row(4, 2, 1);
    get(1'b0, 5, 2, 1'b1, "R2 row read");
    get(1'b0, 4, 2, 1'b1, "R2 row read skew0");
    get(1'b1, 9, 1, 1'b1, "R3 column read");
    get(1'b1, 10, 1, 1'b1, "R3 column read skew2");
  endtask

  task automatic t_sizes_r7;
    for (int code = 0; code < 4; code++) begin
      blk_size = 2'(code);
      fill(2 + code);
      for (int c = 0; c < side(code); c++)
        for (int g = 0; g < side(code) / 4; g++)
          get(1'b1, c, g, 1'b1, "R7 transpose sweep");
    end
  endtask

  task automatic t_clash_r5_r6;
    logic [63:0] d;
    blk_size = 2'd2;
    fill(7);
    for (int k = 0; k < 4; k++) d[k*16 +: 16] = pat(9, 5, 4+k);
    // same tile (1,1): write row 5 group 1, column read of column 6 group 1
    @(negedge clk);
    wr_en = 1'b1; wr_row = 5'd5; wr_grp = 3'd1; wr_data = d;
    rd_en = 1'b1; rd_col = 1'b1; rd_idx = 5'd6; rd_grp = 3'd1;
    #1;
    chk(rd_ready == 1'b0, "R5 clash refused", 64'(rd_ready), 64'(0));
    for (int k = 0; k < 4; k++) model[5][4+k] = d[k*16 +: 16];
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk(rd_valid == 1'b0, "R5 no result", 64'(rd_valid), 64'(0));
    get(1'b0, 5, 1, 1'b1, "R5 write kept");
    // other tile: write tile (0,0) while reading row 4 group 0
    for (int k = 0; k < 4; k++) d[k*16 +: 16] = pat(11, 0, k);
    @(negedge clk);
    wr_en = 1'b1; wr_row = 5'd0; wr_grp = 3'd0; wr_data = d;
    rd_en = 1'b1; rd_col = 1'b0; rd_idx = 5'd4; rd_grp = 3'd0;
    #1;
    chk(rd_ready == 1'b1, "R6 accepted", 64'(rd_ready), 64'(1));
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk(rd_valid == 1'b1, "R6 valid", 64'(rd_valid), 64'(1));
    chk(rd_data == row_exp(4, 0), "R6 data", rd_data, row_exp(4, 0));
    for (int k = 0; k < 4; k++) model[0][k] = d[k*16 +: 16];
    get(1'b0, 0, 0, 1'b1, "R6 write landed");
  endtask

  task automatic t_outside_r8;
    blk_size = 2'd1;
    fill(12);
    put_row(0, 2, 13);
    put_row(8, 0, 13);
    get(1'b0, 0, 0, 1'b1, "R8 ignored write row0");
    get(1'b0, 1, 0, 1'b1, "R8 ignored write row1");
    get(1'b0, 0, 1, 1'b1, "R8 ignored write row0 g1");
    get(1'b0, 8, 0, 1'b0, "R8 read outside row");
    get(1'b1, 2, 2, 1'b0, "R8 read outside column");
  endtask

  task automatic t_stream_r9;
    logic [63:0] e_prev;
    blk_size = 2'd3;
    fill(14);
    for (int i = 0; i <= 32; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk(rd_valid == 1'b1, "R9 valid each cycle", 64'(rd_valid), 64'(1));
        chk(rd_data == e_prev, "R9 stream data", rd_data, e_prev);
      end
      if (i < 32) begin
        rd_en = 1'b1; rd_col = 1'b1; rd_idx = 5'(i); rd_grp = 3'(i % 8);
        e_prev = col_exp(i, i % 8);
        #1;
        chk(rd_ready == 1'b1, "R9 accepted each cycle", 64'(rd_ready), 64'(1));
      end else begin
        rd_en = 1'b0;
      end
    end
    @(negedge clk);
    chk(rd_valid == 1'b0, "R4 valid drops", 64'(rd_valid), 64'(0));
  endtask

  initial begin
    for (int r = 0; r < 32; r++)
      for (int c = 0; c < 32; c++) model[r][c] = '0;
    repeat (3) @(negedge clk);
    t_reset_r1();
    rst_n = 1'b1;
    t_reset_r1();
    t_row_col_r2_r3();
    t_sizes_r7();
    t_clash_r5_r6();
    t_outside_r8();
    t_stream_r9();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule